// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Controller

This block decides which of a device's interrupt sources may interrupt the processor. It also places that source's vector on the data bus during the acknowledge cycle. Each device sits in a serial enable chain. The chain input `iei` grants permission from upstream, and the chain output `ieo` passes permission downstream. A device nearer the processor therefore outranks every device further down. Inside one device, sources are ranked by index: source 0 (port A) outranks source 1 (port B).

Each source holds an 8-bit vector and an enable bit. Both are loaded from the shared bus `din` through per-source write strobes. A request pulse from an enabled source becomes pending. A pending source whose local chain enable is high pulls `int_n` low.

When `m1_n` and `iorq_n` are low together, the claiming source does three things:
- it presents its vector on `vec_o`, with `vec_oe` high;
- it enters service;
- it blocks everything downstream.

The block watches opcode fetches on `din`. A fetch of 0xED followed directly by a fetch of 0x4D ends service for the serving source whose chain enable is high. Because a source in service still blocks only lower-ranked sources, higher-ranked sources can nest.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `int_n` is 1, `vec_oe` is 0, all sources are disabled and idle, and `ieo` equals `iei`.
- R2: `ieo` is 1 only when `iei` is 1 and no source of the device is pending or in service; `iei` low forces `ieo` low.
- R3: `int_n` is 0 exactly when some source is pending and its local chain enable is high. Source 0's chain enable is `iei`. Source 1's chain enable is `iei` with source 0 neither pending nor in service. At most one source claims at a time.
- R4: When sources 0 and 1 are both pending, an acknowledge serves source 0 first.
- R5: `ien_we[i]` loads `din[0]` as source i's enable. A request to a disabled source never becomes pending. Clearing the enable drops a pending request.
- R6: An acknowledge is `m1_n`=0 and `iorq_n`=0 in the same cycle. On the first such cycle, the claiming source leaves pending and enters service. From the next cycle, `vec_oe`=1 and `vec_o` holds its vector until one cycle after the acknowledge ends.
- R7: A fetch is a cycle with `m1_n`=0 and `iorq_n`=1 following a cycle with `m1_n`=1; `din` is the opcode. A fetch of 0xED and then, as the next fetch, 0x4D ends service of the serving source whose chain enable is high.
- R8: While source 1 is in service, a new request on source 0 drives `int_n` low. While source 0 is in service, a request on source 1 does not.
- R9: `vec_we[i]` loads `din` into source i's vector, and that value is returned on the next acknowledge of source i.
- R10: The return sequence seen while `iei` is low ends no local service.
- R11: 0xED followed by any other fetched opcode and then 0x4D is not a return sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iei | input | 1 | Chain enable from upstream |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| din | input | 8 | Data bus: opcode snoop and configuration data |
| req_i | input | 2 | Per-source request pulses, bit 0 = port A |
| ien_we | input | 2 | Per-source enable write strobe (loads din[0]) |
| vec_we | input | 2 | Per-source vector write strobe (loads din) |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Chain enable to downstream |
| vec_o | output | 8 | Vector returned during acknowledge |
| vec_oe | output | 1 | Vector drive enable |

## Verification
The bench builds the block with its defaults: two sources and an 8-bit bus, which matches the port A / port B arrangement. With these values, both sources can be pending and in service at once. That exposes the in-device ordering, nesting in both directions, and return sequences that must pick between two serving sources according to the chain enable. Interleaved fetches around the return opcodes and acknowledges held over several cycles cover the snoop and the vector timing.

// File: rtl/irq_pkg.sv
// Shared constants for the interrupt priority controller.
// Assumes an 8-bit opcode bus for the return sequence.
package irq_pkg;
    localparam logic [7:0] OP_PREFIX = 8'hED;
    localparam logic [7:0] OP_RETURN = 8'h4D;
endpackage

// File: rtl/irq_src_slot.sv
// One interrupt source: holds vector and enable, tracks pending and
// in-service state, and forms its link of the enable chain.
// Assumes ack_start and reti are single-cycle events from the top.
module irq_src_slot #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          ien_we,
    input  logic          vec_we,
    input  logic [DW-1:0] wdata,
    input  logic          iei,
    input  logic          ack_start,
    input  logic          reti,
    output logic          ieo,
    output logic          claim,
    output logic [DW-1:0] vec
);
    logic ien_q, pend_q, serv_q;
    logic take, done;

    assign take  = ack_start & pend_q & iei;
    assign done  = reti & serv_q & iei;
    assign claim = pend_q & iei;
    assign ieo   = iei & ~pend_q & ~serv_q;

    // Configuration registers: enable bit and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
            vec   <= '0;
        end else begin
            if (ien_we) ien_q <= wdata[0];
            if (vec_we) vec   <= wdata;
        end
    end

    // Pending and in-service state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            serv_q <= 1'b0;
        end else begin
            if (!ien_q)    pend_q <= 1'b0;
            else if (take) pend_q <= 1'b0;
            else if (req)  pend_q <= 1'b1;
            if (take)      serv_q <= 1'b1;
            else if (done) serv_q <= 1'b0;
        end
    end

    p_disabled_not_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |=> !pend_q);
    p_ack_enters_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && pend_q && iei) |=> (serv_q && !pend_q));
    p_return_ends_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && serv_q && iei && !ack_start) |=> !serv_q);
    p_return_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (serv_q && !iei) |=> serv_q);
endmodule

// File: rtl/irq_opcode_snoop.sv
// Watches instruction fetches on the bus and flags the two-byte return
// sequence as a one-cycle pulse on the fetch of its second byte.
// Assumes a fetch starts when m1_n falls with iorq_n high.
module irq_opcode_snoop #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m1_n,
    input  logic          iorq_n,
    input  logic [DW-1:0] din,
    output logic          reti
);
    import irq_pkg::*;
    logic m1_q, saw_pfx, fetch;

    assign fetch = ~m1_n & iorq_n & m1_q;
    assign reti  = fetch & saw_pfx & (din == DW'(OP_RETURN));

    // Remember the previous M1 level and whether the last fetch was the prefix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m1_q    <= 1'b1;
            saw_pfx <= 1'b0;
        end else begin
            m1_q <= m1_n;
            if (fetch) saw_pfx <= (din == DW'(OP_PREFIX));
        end
    end

    p_return_needs_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reti |-> ($past(m1_n) && !m1_n && iorq_n));
endmodule

// File: rtl/irq_daisy_ctrl.sv
// Interrupt priority controller for a group of sources joined into an
// external enable chain. Lower index outranks higher index inside the device.
// Assumes an acknowledge drives m1_n and iorq_n low together.
module irq_daisy_ctrl #(
    parameter int NSRC = 2,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iei,
    input  logic            m1_n,
    input  logic            iorq_n,
    input  logic [DW-1:0]   din,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] ien_we,
    input  logic [NSRC-1:0] vec_we,
    output logic            int_n,
    output logic            ieo,
    output logic [DW-1:0]   vec_o,
    output logic            vec_oe
);
    logic [NSRC:0]   chain;
    logic [NSRC-1:0] claim;
    logic [DW-1:0]   vecs [NSRC];
    logic [DW-1:0]   win_vec;
    logic            ack_now, ack_q, ack_start, reti;

    assign chain[0]  = iei;
    assign ieo       = chain[NSRC];
    assign int_n     = ~|claim;
    assign ack_now   = ~m1_n & ~iorq_n;
    assign ack_start = ack_now & ~ack_q;

    irq_opcode_snoop #(.DW(DW)) u_snoop (
        .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .iorq_n(iorq_n),
        .din(din), .reti(reti)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_src_slot #(.DW(DW)) u_slot (
            .clk(clk), .rst_n(rst_n), .req(req_i[i]),
            .ien_we(ien_we[i]), .vec_we(vec_we[i]), .wdata(din),
            .iei(chain[i]), .ack_start(ack_start), .reti(reti),
            .ieo(chain[i+1]), .claim(claim[i]), .vec(vecs[i])
        );
    end

    // Pick the vector of the claiming source; lowest index wins.
    always_comb begin
        win_vec = '0;
        for (int i = NSRC - 1; i >= 0; i--)
            if (claim[i]) win_vec = vecs[i];
    end

    // Capture the winner's vector at acknowledge start and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            vec_oe <= 1'b0;
            vec_o  <= '0;
        end else begin
            ack_q  <= ack_now;
            vec_oe <= ack_now & (ack_start ? |claim : vec_oe);
            if (ack_start) vec_o <= win_vec;
        end
    end

    p_chain_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |-> !ieo);
    p_single_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim));
    p_request_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |-> int_n);
    p_vector_in_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> $past(ack_now));
endmodule

// File: tb/tb_irq_daisy_ctrl.sv
`timescale 1ns/1ps
module tb_irq_daisy_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iei = 1'b1, m1_n = 1'b1, iorq_n = 1'b1;
    logic [7:0] din = '0;
    logic [1:0] req_i = '0, ien_we = '0, vec_we = '0;
    logic       int_n, ieo, vec_oe;
    logic [7:0] vec_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_daisy_ctrl dut (
        .clk(clk), .rst_n(rst_n), .iei(iei), .m1_n(m1_n), .iorq_n(iorq_n),
        .din(din), .req_i(req_i), .ien_we(ien_we), .vec_we(vec_we),
        .int_n(int_n), .ieo(ieo), .vec_o(vec_o), .vec_oe(vec_oe)
    );

    // Stimulus table: {iei, reqA, reqB, exp_int_n, exp_ieo}
    localparam logic [4:0] TBL [4] = '{
        5'b1_00_1_1,
        5'b0_10_1_0,
        5'b1_00_0_0,
        5'b1_01_0_0
    };

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(int i, logic [7:0] v, logic en);
        din = v; vec_we[i] = 1'b1; step(); vec_we = '0;
        din = {7'd0, en}; ien_we[i] = 1'b1; step(); ien_we = '0; din = '0;
    endtask

    task automatic pulse(logic [1:0] m);
        req_i = m; step(); req_i = '0;
    endtask

    task automatic ack(logic [7:0] exp);
        m1_n = 1'b0; iorq_n = 1'b0; step();
        check("R6 vec_oe", {7'd0, vec_oe}, 8'd1);
        check("R4/R9 vector", vec_o, exp);
        step();
        check("R6 held", {7'd0, vec_oe}, 8'd1);
        m1_n = 1'b1; iorq_n = 1'b1; step();
        check("R6 release", {7'd0, vec_oe}, 8'd0);
    endtask

    task automatic fetch(logic [7:0] op);
        m1_n = 1'b0; din = op; step();
        m1_n = 1'b1; din = '0; step();
    endtask

    initial begin
        repeat (3) step();
        check("R1 int_n", {7'd0, int_n}, 8'd1);
        check("R1 vec_oe", {7'd0, vec_oe}, 8'd0);
        check("R1 ieo", {7'd0, ieo}, 8'd1);
        pulse(2'b11);
        check("R1 disabled at reset", {7'd0, int_n}, 8'd1);
        rst_n = 1'b1; step();
        pulse(2'b01);
        check("R5 reset enable clear", {7'd0, int_n}, 8'd1);

        cfg(0, 8'h40, 1'b1);
        cfg(1, 8'h42, 1'b1);
        for (int k = 0; k < 4; k++) begin
            iei = TBL[k][4]; req_i = {TBL[k][2], TBL[k][3]};
            step(); req_i = '0;
            check($sformatf("R3 table int_n %0d", k), {7'd0, int_n}, {7'd0, TBL[k][1]});
            check($sformatf("R2 table ieo %0d", k), {7'd0, ieo}, {7'd0, TBL[k][0]});
        end

        ack(8'h40);
        check("R3 B blocked by A service", {7'd0, int_n}, 8'd1);
        check("R2 ieo low in service", {7'd0, ieo}, 8'd0);
        fetch(8'hED); fetch(8'h4D);
        check("R7 B claims after return", {7'd0, int_n}, 8'd0);
        ack(8'h42);
        pulse(2'b01);
        check("R8 nested A over B", {7'd0, int_n}, 8'd0);
        ack(8'h40);
        pulse(2'b10);
        check("R8 B held off by A", {7'd0, int_n}, 8'd1);
        cfg(1, 8'h42, 1'b0);

        iei = 1'b0; step();
        fetch(8'hED); fetch(8'h4D);
        iei = 1'b1; step();
        fetch(8'hED); fetch(8'h4D);
        check("R10 one return left", {7'd0, ieo}, 8'd0);
        fetch(8'hED); fetch(8'h4D);
        check("R7 all served", {7'd0, ieo}, 8'd1);

        cfg(1, 8'h42, 1'b1);
        pulse(2'b10); ack(8'h42);
        fetch(8'hED); fetch(8'h00); fetch(8'h4D);
        check("R11 broken sequence", {7'd0, ieo}, 8'd0);
        fetch(8'hED); fetch(8'h4D);
        check("R11 clean sequence", {7'd0, ieo}, 8'd1);

        cfg(0, 8'h40, 1'b0);
        pulse(2'b01);
        check("R5 disabled request", {7'd0, int_n}, 8'd1);
        cfg(0, 8'h40, 1'b1);
        pulse(2'b01);
        check("R5 enabled request", {7'd0, int_n}, 8'd0);
        din = 8'h00; ien_we = 2'b01; step(); ien_we = '0; step();
        check("R5 enable clear drops", {7'd0, int_n}, 8'd1);
        check("R5 ieo after drop", {7'd0, ieo}, 8'd1);

        cfg(1, 8'h77, 1'b1);
        pulse(2'b10); ack(8'h77);
        fetch(8'hED); fetch(8'h4D);
        check("R9 served and returned", {7'd0, ieo}, 8'd1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule